// File: doc/BRIEF.md
# DMA Burst and Hold Sequencer

This block paces one DMA channel on a shared system bus. A transfer of a given number of items is split into bursts. While a burst is in progress the channel keeps its bus request raised, and it counts an item only when the bus accepts it. Between two bursts the channel lowers its request for a programmed number of cycles, so that other masters and other channels can win arbitration. The final burst is cut short to the number of items left. A one-cycle done pulse follows it, with no hold period after it.

Software programs a 32-bit configuration word before it starts the channel. The low byte holds the burst field, which stands for one more item than its value. The next byte holds the hold field, and a value of zero is treated as one. The upper half is reserved. The size of each item comes from a separate select input. The select is captured at start and shown as a byte count. Address generation, data movement and arbitration belong to neighbouring blocks.

Top module: `dma_burst_seq`

## Requirements
- R1: After reset, bus_req, busy and done are all low.
- R2: cfg_rdata returns the hold field in bits 15:8 and the burst field in bits 7:0. Bits 31:16 always read zero, and a write to them has no effect.
- R3: Each burst, except a shortened final one, ends after exactly burst field + 1 accepted items, at which point bus_req falls.
- R4: An item is counted only in a cycle where bus_req, bus_grant and beat_accept are all high. Over a transfer, exactly xfer_items items are counted.
- R5: Once bus_req is raised, it stays high through every cycle in which bus_grant is low.
- R6: Between two bursts, bus_req stays low while busy for exactly the hold field's number of cycles.
- R7: A hold field of zero gives a hold period of exactly one cycle.
- R8: The final burst carries only the items left. done is high for exactly one cycle, in the cycle after the last accepted item, and busy falls in that same cycle with no hold period.
- R9: A burst field of zero gives single-item bursts, with a hold period between each pair of items.
- R10: While busy, beat_bytes equals 2 to the power of the xfer_size value captured at start (0→1, 1→2, 2→4, 3→8). Later changes to xfer_size are ignored.
- R11: A start pulse while busy is ignored. A start with xfer_items of zero gives a done pulse in the next cycle and never raises bus_req.
- R12: A burst field of 255 gives bursts of 256 items.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 32 | Configuration write word |
| cfg_rdata | output | 32 | Configuration read word, reserved bits zero |
| xfer_size | input | 2 | Item size select, captured at start |
| xfer_items | input | 16 | Total item count, captured at start |
| start | input | 1 | Start pulse, used only while idle |
| bus_req | output | 1 | Bus request |
| bus_grant | input | 1 | Bus grant |
| beat_accept | input | 1 | Bus accepts the current item |
| beat_bytes | output | 4 | Bytes per item |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The checker watches four things on every cycle: that a waiting request is held until grant, that each low-request gap between bursts lasts the effective hold count, that every full burst ends on burst field + 1 accepted items, and that done is a single idle-cycle pulse. The bench scenarios cover what those properties cannot: the shortened final burst, the total item count under irregular grant and accept patterns, the reserved bits of the configuration word, the item size captured at start, the ignored start while busy, and the zero-item start.

// File: rtl/dma_bs_pkg.sv
package dma_bs_pkg;

   typedef enum logic [1:0] {
      SEQ_IDLE = 2'd0,
      SEQ_XFER = 2'd1,
      SEQ_HOLD = 2'd2
   } seq_state_e;

endpackage

// File: rtl/dma_bs_down_cnt.sv
module dma_bs_down_cnt #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   input  logic         dec,
   output logic [W-1:0] cnt,
   output logic         at_one
);

   if (W < 1) begin : g_bad_w
      $error("dma_bs_down_cnt: W must be at least 1");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (load)
         cnt <= load_val;
      else if (dec && (cnt != '0))
         cnt <= cnt - 1'b1;
   end

   assign at_one = (cnt == W'(1));

endmodule

// File: rtl/dma_bs_cfg.sv
module dma_bs_cfg #(
   parameter int CFG_W   = 32,
   parameter int BURST_W = 8,
   parameter int HOLD_W  = 8
) (
   input  logic               clk,
   input  logic               we,
   input  logic [CFG_W-1:0]   wdata,
   output logic [BURST_W-1:0] burst_fld,
   output logic [HOLD_W-1:0]  hold_fld,
   output logic [CFG_W-1:0]   rdata
);

   localparam int USED_W = BURST_W + HOLD_W;

   if (USED_W > CFG_W) begin : g_bad_fit
      $error("dma_bs_cfg: fields do not fit the configuration word");
   end

   // fields are left unset by reset; software writes them before start
   logic [USED_W-1:0] fld_q;

   always_ff @(posedge clk) begin
      if (we)
         fld_q <= wdata[USED_W-1:0];
   end

   assign burst_fld = fld_q[BURST_W-1:0];
   assign hold_fld  = fld_q[USED_W-1:BURST_W];

   if (CFG_W > USED_W) begin : g_pad
      logic unused_rsvd;
      assign unused_rsvd = ^wdata[CFG_W-1:USED_W];
      assign rdata = {{(CFG_W-USED_W){1'b0}}, fld_q};
   end else begin : g_exact
      assign rdata = fld_q;
   end

endmodule

// File: rtl/dma_burst_seq.sv
module dma_burst_seq #(
   parameter int CFG_W   = 32,
   parameter int BURST_W = 8,
   parameter int HOLD_W  = 8,
   parameter int ITEM_W  = 16,
   parameter int SIZE_W  = 2
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  cfg_we,
   input  logic [CFG_W-1:0]      cfg_wdata,
   output logic [CFG_W-1:0]      cfg_rdata,
   input  logic [SIZE_W-1:0]     xfer_size,
   input  logic [ITEM_W-1:0]     xfer_items,
   input  logic                  start,
   output logic                  bus_req,
   input  logic                  bus_grant,
   input  logic                  beat_accept,
   output logic [2**SIZE_W-1:0]  beat_bytes,
   output logic                  busy,
   output logic                  done
);
   import dma_bs_pkg::*;

   localparam int BLEN_W  = BURST_W + 1;
   localparam int CMP_W   = (ITEM_W > BLEN_W) ? ITEM_W : BLEN_W;
   localparam int BYTES_W = 2 ** SIZE_W;

   if (BURST_W < 1 || HOLD_W < 1 || ITEM_W < 1 || SIZE_W < 1) begin : g_bad_par
      $error("dma_burst_seq: all widths must be at least 1");
   end
   if (SIZE_W > 4) begin : g_bad_size
      $error("dma_burst_seq: SIZE_W too large for a byte-count output");
   end

   // configuration word
   logic [BURST_W-1:0] burst_fld;
   logic [HOLD_W-1:0]  hold_fld;

   dma_bs_cfg #(
      .CFG_W  (CFG_W),
      .BURST_W(BURST_W),
      .HOLD_W (HOLD_W)
   ) u_cfg (
      .clk      (clk),
      .we       (cfg_we),
      .wdata    (cfg_wdata),
      .burst_fld(burst_fld),
      .hold_fld (hold_fld),
      .rdata    (cfg_rdata)
   );

   seq_state_e state_q, state_d;

   logic [ITEM_W-1:0] rem_cnt;
   logic              rem_one;
   logic [BLEN_W-1:0] beat_cnt;
   logic              beat_one;
   logic [HOLD_W-1:0] hold_cnt;
   logic              hold_one;

   // derived burst length and effective hold
   logic [BLEN_W-1:0] blen;
   logic [HOLD_W-1:0] hold_eff;
   logic [CMP_W-1:0]  blen_ext, items_ext, rem_ext;
   logic [BLEN_W-1:0] first_beats, next_beats;

   assign blen      = BLEN_W'(burst_fld) + BLEN_W'(1);
   assign hold_eff  = (hold_fld == '0) ? HOLD_W'(1) : hold_fld;
   assign blen_ext  = CMP_W'(blen);
   assign items_ext = CMP_W'(xfer_items);
   assign rem_ext   = CMP_W'(rem_cnt);

   assign first_beats = (items_ext < blen_ext) ? items_ext[BLEN_W-1:0] : blen;
   assign next_beats  = (rem_ext   < blen_ext) ? rem_ext[BLEN_W-1:0]   : blen;

   // events
   logic start_ok, items_zero, beat, last_beat, final_beat;

   assign start_ok   = (state_q == SEQ_IDLE) && start;
   assign items_zero = (xfer_items == '0);
   assign beat       = (state_q == SEQ_XFER) && bus_grant && beat_accept;
   assign last_beat  = beat && beat_one;
   assign final_beat = last_beat && rem_one;

   // remaining items in the transfer
   dma_bs_down_cnt #(.W(ITEM_W)) u_rem (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (start_ok && !items_zero),
      .load_val(xfer_items),
      .dec     (beat),
      .cnt     (rem_cnt),
      .at_one  (rem_one)
   );

   // items left in the current burst
   dma_bs_down_cnt #(.W(BLEN_W)) u_beat (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    ((start_ok && !items_zero) || ((state_q == SEQ_HOLD) && hold_one)),
      .load_val((state_q == SEQ_IDLE) ? first_beats : next_beats),
      .dec     (beat),
      .cnt     (beat_cnt),
      .at_one  (beat_one)
   );

   // hold cycles left between bursts
   dma_bs_down_cnt #(.W(HOLD_W)) u_hold (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (last_beat && !rem_one),
      .load_val(hold_eff),
      .dec     (state_q == SEQ_HOLD),
      .cnt     (hold_cnt),
      .at_one  (hold_one)
   );

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         SEQ_IDLE: if (start_ok && !items_zero) state_d = SEQ_XFER;
         SEQ_XFER: begin
            if (final_beat)     state_d = SEQ_IDLE;
            else if (last_beat) state_d = SEQ_HOLD;
         end
         SEQ_HOLD: if (hold_one) state_d = SEQ_XFER;
         default:  state_d = SEQ_IDLE;
      endcase
   end

   logic              done_q;
   logic [SIZE_W-1:0] size_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= SEQ_IDLE;
         done_q  <= 1'b0;
         size_q  <= '0;
      end else begin
         state_q <= state_d;
         done_q  <= (start_ok && items_zero) || final_beat;
         if (start_ok)
            size_q <= xfer_size;
      end
   end

   logic unused_cnt;
   assign unused_cnt = ^{beat_cnt, hold_cnt};

   assign bus_req    = (state_q == SEQ_XFER);
   assign busy       = (state_q != SEQ_IDLE);
   assign done       = done_q;
   assign beat_bytes = BYTES_W'(1) << size_q;

endmodule

// File: rtl/dma_burst_seq_chk.sv
module dma_burst_seq_chk #(
   parameter int BURST_W = 8,
   parameter int HOLD_W  = 8
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic                       bus_req,
   input logic                       bus_grant,
   input logic                       beat_accept,
   input logic                       busy,
   input logic                       done,
   input logic [BURST_W+HOLD_W-1:0]  cfg_flds
);

   logic [HOLD_W:0]    low_cnt;
   logic [BURST_W+1:0] acc_cnt;
   logic [HOLD_W:0]    hold_exp;
   logic [BURST_W+1:0] blen_exp;

   assign hold_exp = (cfg_flds[BURST_W+HOLD_W-1:BURST_W] == '0) ?
                     (HOLD_W+1)'(1) : (HOLD_W+1)'(cfg_flds[BURST_W+HOLD_W-1:BURST_W]);
   assign blen_exp = (BURST_W+2)'(cfg_flds[BURST_W-1:0]) + (BURST_W+2)'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         low_cnt <= '0;
         acc_cnt <= '0;
      end else begin
         low_cnt <= (busy && !bus_req) ? low_cnt + 1'b1 : '0;
         if (!bus_req)
            acc_cnt <= '0;
         else if (bus_grant && beat_accept)
            acc_cnt <= acc_cnt + 1'b1;
      end
   end

   // R5
   req_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_req && !bus_grant |=> bus_req);

   // R6
   hold_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_req && (low_cnt != '0) |-> low_cnt == hold_exp);

   // R3
   burst_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(bus_req) && busy |-> acc_cnt == blen_exp);

   // R8
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R8
   done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy && !bus_req);

   // R11
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !bus_req);

endmodule

bind dma_burst_seq dma_burst_seq_chk #(
   .BURST_W(BURST_W),
   .HOLD_W (HOLD_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .bus_req    (bus_req),
   .bus_grant  (bus_grant),
   .beat_accept(beat_accept),
   .busy       (busy),
   .done       (done),
   .cfg_flds   (cfg_rdata[BURST_W+HOLD_W-1:0])
);

// File: tb/dma_burst_seq_bench.sv
`timescale 1ns/1ps
module dma_burst_seq_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [31:0] cfg_wdata = '0;
   logic [31:0] cfg_rdata;
   logic [1:0]  xfer_size = '0;
   logic [15:0] xfer_items = '0;
   logic        start = 1'b0;
   logic        bus_req;
   logic        bus_grant = 1'b0;
   logic        beat_accept = 1'b0;
   logic [3:0]  beat_bytes;
   logic        busy;
   logic        done;

   int errors = 0;
   int checks = 0;

   always #2 clk = ~clk;

   dma_burst_seq u_dma_burst_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .cfg_we     (cfg_we),
      .cfg_wdata  (cfg_wdata),
      .cfg_rdata  (cfg_rdata),
      .xfer_size  (xfer_size),
      .xfer_items (xfer_items),
      .start      (start),
      .bus_req    (bus_req),
      .bus_grant  (bus_grant),
      .beat_accept(beat_accept),
      .beat_bytes (beat_bytes),
      .busy       (busy),
      .done       (done)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
      end
   endtask

   task automatic step_clk();
      @(posedge clk);
      #1;
   endtask

   task automatic write_cfg(input logic [31:0] w);
      cfg_we    = 1'b1;
      cfg_wdata = w;
      step_clk();
      cfg_we    = 1'b0;
   endtask

   // runs one transfer, checking burst lengths, hold gaps, done timing
   task automatic run_xfer(input int items, input int bcnt, input int hcnt,
                           input int gper, input int aper, input int mid_start,
                           input int size, output int total, output int nbursts,
                           output int last_hold, output int max_burst);
      int  rem_exp = items;
      int  blen    = bcnt + 1;
      int  exp_h   = (hcnt == 0) ? 1 : hcnt;
      int  exp_b   = 1 << size;
      int  acc_burst = 0;
      int  low = 0;
      int  step = 0;
      int  exp_len;
      bit  was_req = 0, g_prev = 0, acc_pend = 0, fin = 0, size_bad = 0;
      total = 0; nbursts = 0; last_hold = 0; max_burst = 0;
      write_cfg({16'hFFFF, hcnt[7:0], bcnt[7:0]});
      xfer_items = 16'(items);
      xfer_size  = 2'(size);
      start      = 1'b1;
      step_clk();
      start      = 1'b0;
      while (!fin && step < 5000) begin
         if (acc_pend) begin
            acc_burst++;
            total++;
            if (acc_burst > max_burst) max_burst = acc_burst;
         end
         if (was_req && !g_prev)
            chk(bus_req == 1'b1, "R5", "request held without grant", bus_req, 1);
         if (was_req && !bus_req) begin
            exp_len = (rem_exp < blen) ? rem_exp : blen;
            chk(acc_burst == exp_len, "R3", "items in burst", acc_burst, exp_len);
            rem_exp -= acc_burst;
            nbursts++;
            acc_burst = 0;
            if (rem_exp <= 0) begin
               chk(done == 1'b1, "R8", "done after final burst", done, 1);
               chk(busy == 1'b0, "R8", "busy after final burst", busy, 0);
               fin = 1;
            end else begin
               chk(done == 1'b0 && busy == 1'b1, "R8", "done before final burst", done, 0);
            end
         end
         if (!was_req && bus_req && low > 0) begin
            chk(low == exp_h, "R6", "hold cycles", low, exp_h);
            last_hold = low;
         end
         if (busy && !bus_req) low++; else low = 0;
         if (busy && beat_bytes != 4'(exp_b)) size_bad = 1;
         // drive next cycle
         was_req     = bus_req;
         g_prev      = bus_req && (gper == 0 || (step % gper) != 0);
         bus_grant   = g_prev;
         beat_accept = (aper == 0 || (step % aper) != 1);
         acc_pend    = bus_req && g_prev && beat_accept;
         xfer_size   = 2'(step);
         start       = (step == mid_start);
         if (step == mid_start) xfer_items = 16'd7;
         step++;
         step_clk();
      end
      start       = 1'b0;
      bus_grant   = 1'b0;
      beat_accept = 1'b0;
      chk(fin, "R8", "transfer completed", fin, 1);
      chk(done == 1'b0, "R8", "done lasts one cycle", done, 0);
      chk(total == items, "R4", "items accepted in transfer", total, items);
      chk(!size_bad, "R10", "beat_bytes held from start", size_bad, 0);
   endtask

   task automatic t_reset();
      chk(bus_req == 1'b0, "R1", "bus_req after reset", bus_req, 0);
      chk(busy == 1'b0, "R1", "busy after reset", busy, 0);
      chk(done == 1'b0, "R1", "done after reset", done, 0);
   endtask

   task automatic t_cfg();
      write_cfg(32'hFFFF_A5C3);
      chk(cfg_rdata == 32'h0000_A5C3, "R2", "readback with reserved set", cfg_rdata, 32'h0000_A5C3);
      write_cfg(32'h1234_0000);
      chk(cfg_rdata == 32'h0, "R2", "reserved write ignored", cfg_rdata, 0);
   endtask

   task automatic t_basic();
      int tot, nb, lh, mb;
      run_xfer(10, 3, 2, 0, 0, -1, 2, tot, nb, lh, mb);
      chk(nb == 3, "R8", "bursts for 10 items of 4", nb, 3);
      chk(mb == 4, "R3", "full burst length", mb, 4);
   endtask

   task automatic t_zero_hold();
      int tot, nb, lh, mb;
      run_xfer(8, 3, 0, 3, 2, -1, 1, tot, nb, lh, mb);
      chk(lh == 1, "R7", "zero hold acts as one", lh, 1);
      chk(nb == 2, "R3", "bursts for 8 items of 4", nb, 2);
   endtask

   task automatic t_single();
      int tot, nb, lh, mb;
      run_xfer(4, 0, 3, 0, 3, -1, 0, tot, nb, lh, mb);
      chk(mb == 1, "R9", "single-item bursts", mb, 1);
      chk(nb == 4, "R9", "one burst per item", nb, 4);
      chk(lh == 3, "R9", "hold between items", lh, 3);
   endtask

   task automatic t_stall();
      int tot, nb, lh, mb;
      run_xfer(9, 2, 2, 4, 3, -1, 0, tot, nb, lh, mb);
      chk(tot == 9, "R4", "items under grant and accept stalls", tot, 9);
   endtask

   task automatic t_big();
      int tot, nb, lh, mb;
      run_xfer(300, 255, 1, 0, 0, -1, 3, tot, nb, lh, mb);
      chk(mb == 256, "R12", "largest burst", mb, 256);
      chk(nb == 2, "R12", "bursts for 300 items", nb, 2);
   endtask

   task automatic t_restart();
      int tot, nb, lh, mb;
      run_xfer(6, 1, 1, 2, 0, 3, 2, tot, nb, lh, mb);
      chk(tot == 6, "R11", "start while busy ignored", tot, 6);
      chk(nb == 3, "R11", "burst count unchanged by restart", nb, 3);
   endtask

   task automatic t_zero_items();
      xfer_items = 16'd0;
      start      = 1'b1;
      step_clk();
      start      = 1'b0;
      chk(done == 1'b1, "R11", "done for zero items", done, 1);
      chk(bus_req == 1'b0, "R11", "no request for zero items", bus_req, 0);
      step_clk();
      chk(done == 1'b0, "R11", "zero-item done is one cycle", done, 0);
      chk(busy == 1'b0, "R11", "idle after zero items", busy, 0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      rst_n = 1'b1;
      step_clk();
      t_reset();
      t_cfg();
      t_basic();
      t_zero_hold();
      t_single();
      t_stall();
      t_big();
      t_restart();
      t_zero_items();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule